// File: doc/BRIEF.md
# Message-Line Write-Combining Buffer

This block sits between a core's store path and the message-buffer memory. Stores marked as message-typed are not written out one at a time. They are merged into a single buffer that holds exactly one aligned cache line. The buffer keeps a valid bit for every byte. When every byte of the line is valid, the buffer sends the whole line downstream as one burst of beats. A message-typed store to a different line first pushes out the partially filled line, with byte enables for the bytes that were written. That store then starts a new line in the buffer.

Stores without the message type do not enter the buffer. Each one goes out as a single write, after any line still held in the buffer has been drained. The downstream side uses a valid/ready handshake. The store input stalls while any write, burst or single, is waiting to complete. With the default parameters a line is 32 bytes, sent as eight 32-bit beats.

Top module: `msg_wc_buffer`

## Requirements
- R1: Out of reset the output is idle (`wr_valid_o` = 0) and the store input is ready (`st_ready_o` = 1).
- R2: Message-typed stores (`st_msg_i` = 1) into one line produce no downstream write while some byte of that line is still unwritten.
- R3: When all bytes of the buffered line are valid, the line is sent as BEATS beats with `wr_burst_o` = 1. The beats come in ascending address order: beat i is at line base + i*(DATA_W/8). `wr_last_o` is set only on the final beat, and every byte enable is set.
- R4: A message-typed store whose line address (`st_addr_i` above the line-offset bits) differs from the buffered line first flushes the buffered line. That flush is a full BEATS-beat burst whose byte enables mark only the bytes that were written, so beats never written carry enable 0. The new store then starts a fresh line that holds only its own bytes.
- R5: A store to a byte that is already valid in the buffered line overwrites the old value and does not cause a flush.
- R6: A store with `st_msg_i` = 0 leaves as one write with `wr_burst_o` = 0 and `wr_last_o` = 1, carrying its own address, data and byte enables. If a line is buffered, that line is emitted first.
- R7: While `wr_valid_o` is high, `st_ready_o` is low. While `wr_ready_i` is low, the presented write is held stable.
- R8: Byte enable bit k of a store (`st_be_i[k]`) selects data bits [8k+7:8k]. Only the enabled bytes are merged into the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted when high together with st_valid_i |
| st_addr_i | input | ADDR_W | Store byte address, aligned to the data word |
| st_data_i | input | DATA_W | Store data |
| st_be_i | input | DATA_W/8 | Store byte enables |
| st_msg_i | input | 1 | Store targets uncached message-typed memory |
| wr_valid_o | output | 1 | Downstream write beat valid |
| wr_ready_i | input | 1 | Downstream accepts the beat |
| wr_addr_o | output | ADDR_W | Beat address |
| wr_data_o | output | DATA_W | Beat data |
| wr_be_o | output | DATA_W/8 | Beat byte enables |
| wr_burst_o | output | 1 | Beat belongs to a line burst (0 means a single write) |
| wr_last_o | output | 1 | Final beat of the write |

## Verification
The assertions assume that store addresses are aligned to the data word, so the low byte-offset bits of `st_addr_i` are zero. They also assume that a store request, once raised, keeps its fields stable until it is accepted. The bench's store task holds every field until it sees `st_ready_o` high at a clock edge, and it uses only word-aligned addresses. The bench changes `wr_ready_i` only between edges, following a fixed pattern. This exercises back-pressure without changing the handshake in the middle of a cycle.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  typedef enum logic [1:0] {
    WCB_IDLE   = 2'd0,
    WCB_FLUSH  = 2'd1,
    WCB_SINGLE = 2'd2
  } wcb_state_e;
endpackage

// File: rtl/wcb_line_store.sv
module wcb_line_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BEATS  = 8,
  parameter int unsigned TAG_W  = 27,
  localparam int unsigned BYTES  = DATA_W / 8,
  localparam int unsigned BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [BEAT_W-1:0] wr_beat_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BYTES-1:0]  wr_be_i,
  input  logic              clear_i,
  input  logic [BEAT_W-1:0] rd_beat_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic              occupied_o,
  output logic              full_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [BYTES-1:0]  rd_be_o
);
  logic [DATA_W-1:0] line_q [BEATS];
  logic [BYTES-1:0]  bv_q   [BEATS];
  logic [TAG_W-1:0]  tag_q;
  logic              occ_q;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bv_q[b]   <= '0;
        line_q[b] <= '0;
      end else if (clear_i) begin
        bv_q[b] <= '0;
      end else if (wr_en_i && wr_beat_i == BEAT_W'(b)) begin
        bv_q[b] <= bv_q[b] | wr_be_i;
        for (int k = 0; k < BYTES; k++) begin
          if (wr_be_i[k]) line_q[b][8*k +: 8] <= wr_data_i[8*k +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= 1'b0;
      tag_q <= '0;
    end else if (clear_i) begin
      occ_q <= 1'b0;
    end else if (wr_en_i) begin
      occ_q <= 1'b1;
      tag_q <= wr_tag_i;
    end
  end

  always_comb begin
    full_o = occ_q;
    for (int b = 0; b < BEATS; b++) full_o = full_o & (&bv_q[b]);
  end

  assign tag_o      = tag_q;
  assign occupied_o = occ_q;
  assign rd_data_o  = line_q[rd_beat_i];
  assign rd_be_o    = bv_q[rd_beat_i];

  // R4: a merge into a live line must target that same line
  a_r4_same_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && occ_q) |-> (wr_tag_i == tag_q));
endmodule

// File: rtl/wcb_ctrl.sv
module wcb_ctrl
  import wcb_pkg::*;
#(
  parameter int unsigned BEATS = 8,
  localparam int unsigned BEAT_W = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic              st_msg_i,
  input  logic              hit_i,
  input  logic              occupied_i,
  input  logic              full_i,
  input  logic              wr_ready_i,
  output logic              st_ready_o,
  output logic              line_wr_o,
  output logic              single_ld_o,
  output logic              clear_o,
  output wcb_state_e        state_o,
  output logic [BEAT_W-1:0] beat_o
);
  wcb_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              conflict, accept, last_beat;

  assign conflict    = st_valid_i && occupied_i && (!st_msg_i || !hit_i);
  assign st_ready_o  = (state_q == WCB_IDLE) && !full_i && !conflict;
  assign accept      = st_valid_i && st_ready_o;
  assign line_wr_o   = accept && st_msg_i;
  assign single_ld_o = accept && !st_msg_i;
  assign last_beat   = (beat_q == BEAT_W'(BEATS - 1));

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    clear_o = 1'b0;
    unique case (state_q)
      WCB_IDLE: begin
        if (full_i || conflict) begin
          state_d = WCB_FLUSH;
          beat_d  = '0;
        end else if (single_ld_o) begin
          state_d = WCB_SINGLE;
        end
      end
      WCB_FLUSH: begin
        if (wr_ready_i) begin
          if (last_beat) begin
            state_d = WCB_IDLE;
            clear_o = 1'b1;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      WCB_SINGLE: if (wr_ready_i) state_d = WCB_IDLE;
      default: state_d = WCB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WCB_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/wcb_emit.sv
module wcb_emit
  import wcb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BEATS  = 8,
  localparam int unsigned BYTES  = DATA_W / 8,
  localparam int unsigned BEAT_W = $clog2(BEATS),
  localparam int unsigned BYTE_W = $clog2(BYTES),
  localparam int unsigned TAG_W  = ADDR_W - BEAT_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              single_ld_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [BYTES-1:0]  st_be_i,
  input  wcb_state_e        state_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic [BYTES-1:0]  line_be_i,
  input  logic              wr_ready_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [BYTES-1:0]  wr_be_o,
  output logic              wr_burst_o,
  output logic              wr_last_o
);
  logic [ADDR_W-1:0] s_addr_q;
  logic [DATA_W-1:0] s_data_q;
  logic [BYTES-1:0]  s_be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_addr_q <= '0;
      s_data_q <= '0;
      s_be_q   <= '0;
    end else if (single_ld_i) begin
      s_addr_q <= st_addr_i;
      s_data_q <= st_data_i;
      s_be_q   <= st_be_i;
    end
  end

  always_comb begin
    wr_valid_o = 1'b0;
    wr_burst_o = 1'b0;
    wr_last_o  = 1'b0;
    wr_addr_o  = s_addr_q;
    wr_data_o  = s_data_q;
    wr_be_o    = s_be_q;
    if (state_i == WCB_FLUSH) begin
      wr_valid_o = 1'b1;
      wr_burst_o = 1'b1;
      wr_last_o  = (beat_i == BEAT_W'(BEATS - 1));
      wr_addr_o  = {tag_i, beat_i, {BYTE_W{1'b0}}};
      wr_data_o  = line_data_i;
      wr_be_o    = line_be_i;
    end else if (state_i == WCB_SINGLE) begin
      wr_valid_o = 1'b1;
      wr_last_o  = 1'b1;
    end
  end

  a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)
      && $stable(wr_be_o) && $stable(wr_burst_o) && $stable(wr_last_o)));
endmodule

// File: rtl/msg_wc_buffer.sv
module msg_wc_buffer
  import wcb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BEATS  = 8,
  localparam int unsigned BYTES  = DATA_W / 8,
  localparam int unsigned BEAT_W = $clog2(BEATS),
  localparam int unsigned BYTE_W = $clog2(BYTES),
  localparam int unsigned OFF_W  = BEAT_W + BYTE_W,
  localparam int unsigned TAG_W  = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [BYTES-1:0]  st_be_i,
  input  logic              st_msg_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [BYTES-1:0]  wr_be_o,
  output logic              wr_burst_o,
  output logic              wr_last_o
);
  logic [TAG_W-1:0]  tag, st_tag;
  logic [BEAT_W-1:0] st_beat, beat;
  logic              occupied, full, hit, line_wr, single_ld, clear;
  logic [DATA_W-1:0] line_data;
  logic [BYTES-1:0]  line_be;
  wcb_state_e        state;

  assign st_tag  = st_addr_i[ADDR_W-1:OFF_W];
  assign st_beat = st_addr_i[OFF_W-1:BYTE_W];
  assign hit     = (st_tag == tag);

  wcb_line_store #(.DATA_W(DATA_W), .BEATS(BEATS), .TAG_W(TAG_W)) u_line (
    .clk_i, .rst_ni,
    .wr_en_i(line_wr), .wr_tag_i(st_tag), .wr_beat_i(st_beat),
    .wr_data_i(st_data_i), .wr_be_i(st_be_i), .clear_i(clear),
    .rd_beat_i(beat), .tag_o(tag), .occupied_o(occupied), .full_o(full),
    .rd_data_o(line_data), .rd_be_o(line_be)
  );

  wcb_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk_i, .rst_ni,
    .st_valid_i, .st_msg_i, .hit_i(hit), .occupied_i(occupied), .full_i(full),
    .wr_ready_i, .st_ready_o, .line_wr_o(line_wr), .single_ld_o(single_ld),
    .clear_o(clear), .state_o(state), .beat_o(beat)
  );

  wcb_emit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_emit (
    .clk_i, .rst_ni,
    .single_ld_i(single_ld), .st_addr_i, .st_data_i, .st_be_i,
    .state_i(state), .beat_i(beat), .tag_i(tag),
    .line_data_i(line_data), .line_be_i(line_be), .wr_ready_i,
    .wr_valid_o, .wr_addr_o, .wr_data_o, .wr_be_o, .wr_burst_o, .wr_last_o
  );

  a_r7_stall_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !st_ready_o);

  a_r3_beat_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_burst_o && wr_ready_i && !wr_last_o) |=>
      (wr_valid_o && wr_burst_o && wr_addr_o == $past(wr_addr_o) + ADDR_W'(BYTES)));

  a_r4_line_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_burst_o && wr_last_o && wr_ready_i) |=> !occupied);

  a_r6_single_one_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_burst_o && wr_ready_i) |=> !wr_valid_o);
endmodule

// File: tb/msg_wc_buffer_bench.sv
module msg_wc_buffer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, st_ready, st_msg = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [3:0]  st_be = '0;
  logic        wr_valid, wr_ready = 1'b1, wr_burst, wr_last;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;

  always #2 clk = ~clk;

  msg_wc_buffer u_msg_wc_buffer (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_addr_i(st_addr),
    .st_data_i(st_data), .st_be_i(st_be), .st_msg_i(st_msg),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_be_o(wr_be), .wr_burst_o(wr_burst), .wr_last_o(wr_last)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  be;
    logic        burst;
    logic        last;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int total = 0, bad = 0;
  bit finished = 0;
  int rdy_mode = 0;
  int cyc = 0;
  string full_tag = "R3";

  // reference line image
  logic [7:0]  mb [32];
  logic        mv [32];
  logic [26:0] mtag;
  bit          mocc = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void push_line(input string tag);
    for (int i = 0; i < 8; i++) begin
      item_t it;
      it.a = {mtag, 3'(i), 2'b00};
      it.d = '0;
      it.be = '0;
      for (int k = 0; k < 4; k++) begin
        it.be[k] = mv[4*i+k];
        it.d[8*k +: 8] = mb[4*i+k];
      end
      it.burst = 1'b1;
      it.last = (i == 7);
      it.tag = tag;
      exp_q.push_back(it);
    end
    for (int j = 0; j < 32; j++) mv[j] = 1'b0;
    mocc = 0;
  endfunction

  task automatic do_store(input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] be, input logic msg);
    bit all;
    if (msg) begin
      if (mocc && a[31:5] != mtag) push_line("R4");
      mtag = a[31:5];
      mocc = 1;
      for (int k = 0; k < 4; k++)
        if (be[k]) begin
          mb[{a[4:2], 2'(k)}] = d[8*k +: 8];
          mv[{a[4:2], 2'(k)}] = 1'b1;
        end
      all = 1;
      for (int j = 0; j < 32; j++) all &= mv[j];
      if (all) push_line(full_tag);
    end else begin
      item_t it;
      if (mocc) push_line("R6");
      it.a = a; it.d = d; it.be = be; it.burst = 1'b0; it.last = 1'b1; it.tag = "R6";
      exp_q.push_back(it);
    end
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_msg = msg;
    #1;
    while (!st_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    st_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3", "pending expected beats", 64'(exp_q.size()), 0);
  endtask

  // downstream ready pattern
  initial forever begin
    @(negedge clk);
    cyc++;
    case (rdy_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = (cyc % 3 != 0);
      default: wr_ready = 1'b0;
    endcase
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected write addr", 64'(wr_addr), 0);
      end else begin
        item_t e;
        logic [31:0] m;
        e = exp_q.pop_front();
        m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
        check(wr_addr == e.a, e.tag, "addr", 64'(wr_addr), 64'(e.a));
        check(wr_be == e.be, e.tag, "byte enables", 64'(wr_be), 64'(e.be));
        check((wr_data & m) == (e.d & m), e.tag, "data", 64'(wr_data & m), 64'(e.d & m));
        check(wr_burst == e.burst && wr_last == e.last, e.tag, "burst/last",
              64'({wr_burst, wr_last}), 64'({e.burst, e.last}));
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 32; j++) begin mb[j] = '0; mv[j] = 1'b0; end
    mtag = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check(wr_valid == 1'b0, "R1", "wr_valid in reset", 64'(wr_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(st_ready == 1'b1 && wr_valid == 1'b0, "R1", "ready/valid after reset",
          64'({st_ready, wr_valid}), 64'(2'b10));

    // R3: full line in order, stores byte-enabled per word (R8)
    for (int i = 0; i < 8; i++) do_store(32'h100 + 32'(4*i), 32'hA0B0C000 + 32'(i), 4'hF, 1'b1);
    drain();

    // R2 / R4: partial line then a store to another line
    do_store(32'h204, 32'h11223344, 4'b0011, 1'b1);
    do_store(32'h214, 32'h55667788, 4'b1000, 1'b1);
    repeat (5) @(negedge clk);
    #1;
    check(wr_valid == 1'b0, "R2", "no write for partial line", 64'(wr_valid), 0);
    do_store(32'h300, 32'hCAFEF00D, 4'hF, 1'b1);
    drain();
    // R6: bypass store drains the 0x300 line first
    do_store(32'h1004, 32'hDEADBEEF, 4'b0110, 1'b0);
    drain();
    // R6: bypass with empty buffer
    do_store(32'h2008, 32'h0BADC0DE, 4'hF, 1'b0);
    drain();

    // R5: overwrite a byte, no flush
    full_tag = "R5";
    do_store(32'h408, 32'h12345678, 4'hF, 1'b1);
    do_store(32'h408, 32'h000000EE, 4'b0001, 1'b1);
    repeat (5) @(negedge clk);
    #1;
    check(wr_valid == 1'b0, "R5", "no flush on overwrite", 64'(wr_valid), 0);
    for (int i = 0; i < 8; i++)
      if (i != 2) do_store(32'h400 + 32'(4*i), 32'h5A5A0000 + 32'(i), 4'hF, 1'b1);
    drain();
    full_tag = "R3";

    // R7 / R8: downstream stalled, line built from byte stores in reverse order
    rdy_mode = 2;
    for (int i = 7; i >= 0; i--)
      for (int k = 0; k < 4; k++)
        do_store(32'h600 + 32'(4*i), 32'(8'(16*i + k)) << (8*k), 4'(1 << k), 1'b1);
    repeat (4) @(negedge clk);
    #1;
    check(wr_valid == 1'b1 && st_ready == 1'b0, "R7", "stall while write pending",
          64'({wr_valid, st_ready}), 64'(2'b10));
    rdy_mode = 1;
    drain();

    // R3 / R4 under throttled ready: conflict then full line
    do_store(32'h71C, 32'h99999999, 4'hF, 1'b1);
    for (int i = 0; i < 8; i++) do_store(32'h800 + 32'(4*i), 32'h31415900 + 32'(i), 4'hF, 1'b1);
    drain();
    rdy_mode = 0;

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule